// File: doc/BRIEF.md
# Ethernet receive fragment status generator

This block takes the byte stream of an Ethernet receive MAC and splits each frame across one or more receive buffers. It produces one write strobe per stored byte and, when a fragment closes, a single 32-bit status word that a descriptor-based receive DMA writes back next to the buffer. The buffer capacity comes from a simple descriptor interface: `buf_size_i` gives the capacity minus one, and `desc_avail_i` says whether a buffer can be claimed. The first buffer is claimed at the start-of-frame byte. Each further buffer is claimed in the cycle the current one fills.

Error flags from the MAC arrive together with the end-of-frame byte. They are placed only into the status of the final fragment. Earlier fragments carry zeros there. A filter failure stops the storing of the frame from the flagged byte onward, unless the pass control bit is set. Three events end a frame early: a full buffer with no free descriptor, a byte that arrives while the downstream side is not ready, and a start-of-frame byte with no descriptor. After any of them the block ignores input until the next start-of-frame byte.

Top module: `rx_frag_status`

## Requirements
- R1: Each byte that is stored appears on `wr_en_o`/`wr_data_o` one cycle after it was presented, in arrival order. Bytes of a frame that has been terminated, and bytes that arrive outside a frame, are never written.
- R2: Status bits 10:0 hold the number of bytes written into that fragment minus one, taken modulo 2048. A fragment that holds no bytes reports 0x7FF. Bits 17:11 are always 0.
- R3: `stat_valid_o` pulses one cycle after the byte that closes a fragment. Bit 30 is 1 on the final fragment of a frame, and this includes a frame that fits in a single fragment.
- R4: When a byte fills the buffer (capacity is `buf_size_i`+1, sampled when the buffer was claimed), the frame has not ended and `desc_avail_i` is 1, the fragment closes with bit 30 = 0. The next byte starts a fresh fragment sized from `buf_size_i` in the closing cycle.
- R5: On any status word with bit 30 = 0, bits 27:18 and bit 31 are 0.
- R6: When a frame ends with its end-of-frame byte, the final status copies `mac_stat_i`, sampled with that byte, as follows: bit0 control→18, bit1 VLAN→19, bit2 multicast→21, bit3 broadcast→22, bit4 CRC→23, bit5 symbol→24, bit6 length→25, bit7 range→26, bit8 alignment→27.
- R7: Bit 31 (Error) equals the OR of status bits 23 through 28.
- R8: If `filt_fail_i` is 1 on any byte of a frame and `pass_filt_i` is 0, that byte and all later bytes of the frame are not written. Status still follows at the end-of-frame byte. If `pass_filt_i` is 1, every byte is written. Either way, bit 20 of the final end-of-frame status is 1 when the filter failed.
- R9: When a byte fills the buffer before the end of the frame and `desc_avail_i` is 0, the fragment closes with bit 29 (NoDescriptor) and bit 30 set and bits 27:18 clear. The rest of the frame is discarded.
- R10: A byte that would be written while `wr_ready_i` is 0 is not written. It closes the fragment with bit 28 (Overrun), bit 30 and bit 31 set and bits 27:18 clear. The rest of the frame is discarded.
- R11: A start-of-frame byte presented with `desc_avail_i` = 0 drops the whole frame. No write and no status word are produced.
- R12: While `rst_ni` is low, `wr_en_o` and `stat_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A receive byte is present |
| in_data_i | input | DATA_W | Receive byte |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_eof_i | input | 1 | Byte is the last of a frame |
| mac_stat_i | input | 9 | MAC end-of-frame flags, valid with the end-of-frame byte |
| filt_fail_i | input | 1 | Frame has failed the address filter |
| pass_filt_i | input | 1 | Store filter-failed frames in full |
| desc_avail_i | input | 1 | A receive buffer can be claimed |
| buf_size_i | input | SIZE_W | Buffer capacity minus one |
| wr_ready_i | input | 1 | Downstream can take a byte |
| wr_en_o | output | 1 | Byte write strobe |
| wr_data_o | output | DATA_W | Byte to write |
| stat_valid_o | output | 1 | Status word valid |
| stat_word_o | output | 32 | Fragment status word |

## Verification
The hardest cases to reach are the ones where two closing causes meet in one byte. Examples are a buffer that fills on the end-of-frame byte, an overrun on the end-of-frame byte, and a filter failure on the first byte after a continuation, which leaves an empty fragment. A sweep over small buffer capacities, frame lengths and event positions lands these coincidences on every boundary. A per-byte model in the bench tracks the descriptor count, so it can withhold `desc_avail_i` exactly when a buffer fills.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
  localparam int MAC_W = 9;
  localparam int STAT_W = 32;

  localparam int B_CTRL   = 18;
  localparam int B_VLAN   = 19;
  localparam int B_FAIL   = 20;
  localparam int B_MCAST  = 21;
  localparam int B_BCAST  = 22;
  localparam int B_CRC    = 23;
  localparam int B_SYM    = 24;
  localparam int B_LEN    = 25;
  localparam int B_RNG    = 26;
  localparam int B_ALN    = 27;
  localparam int B_OVR    = 28;
  localparam int B_NODESC = 29;
  localparam int B_LAST   = 30;
  localparam int B_ERR    = 31;

  // status position of each mac_stat_i bit
  localparam int MAC_POS [MAC_W] = '{B_CTRL, B_VLAN, B_MCAST, B_BCAST,
                                     B_CRC, B_SYM, B_LEN, B_RNG, B_ALN};

  typedef enum logic {ST_IDLE, ST_ACT} rx_state_e;
endpackage

// File: rtl/rxfs_frag_ctr.sv
module rxfs_frag_ctr #(
  parameter int SIZE_W = 11,
  localparam int CNT_W = SIZE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reload_i,
  input  logic              write_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  output logic [CNT_W-1:0]  cnt_next_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [SIZE_W-1:0] cap_q;
  logic [SIZE_W-1:0] cap_cur;
  logic [CNT_W-1:0]  cnt_base;

  always_comb begin
    cnt_base   = start_i ? '0 : cnt_q;
    cap_cur    = start_i ? buf_size_i : cap_q;
    cnt_next_o = cnt_base + CNT_W'(write_i);
    full_o     = write_i && (cnt_next_o == ({1'b0, cap_cur} + CNT_W'(1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else if (reload_i) begin
      cnt_q <= '0;
      cap_q <= buf_size_i;
    end else begin
      cnt_q <= cnt_next_o;
      if (start_i) cap_q <= buf_size_i;
    end
  end
endmodule

// File: rtl/rxfs_wr_stage.sv
module rxfs_wr_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              write_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= write_i;
      if (write_i) wr_data_o <= data_i;
    end
  end
endmodule

// File: rtl/rxfs_stat_pack.sv
module rxfs_stat_pack
  import rxfs_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              last_i,
  input  logic              ovr_i,
  input  logic              nodesc_i,
  input  logic              fail_i,
  input  logic              mac_en_i,
  input  logic [MAC_W-1:0]  mac_i,
  output logic              stat_valid_o,
  output logic [STAT_W-1:0] stat_word_o
);
  logic [STAT_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[SIZE_W-1:0] = size_i;
    for (int i = 0; i < MAC_W; i++) word_d[MAC_POS[i]] = mac_en_i & mac_i[i];
    word_d[B_FAIL]   = mac_en_i & fail_i;
    word_d[B_OVR]    = ovr_i;
    word_d[B_NODESC] = nodesc_i;
    word_d[B_LAST]   = last_i;
    word_d[B_ERR]    = |word_d[B_OVR:B_CRC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_valid_o <= 1'b0;
      stat_word_o  <= '0;
    end else begin
      stat_valid_o <= close_i;
      if (close_i) stat_word_o <= word_d;
    end
  end
endmodule

// File: rtl/rx_frag_status.sv
module rx_frag_status
  import rxfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SIZE_W = 11,
  localparam int CNT_W = SIZE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [MAC_W-1:0]  mac_stat_i,
  input  logic              filt_fail_i,
  input  logic              pass_filt_i,
  input  logic              desc_avail_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  input  logic              wr_ready_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              stat_valid_o,
  output logic [STAT_W-1:0] stat_word_o
);
  rx_state_e        state_q, state_d;
  logic             fail_q;
  logic             start, go, take, fail_now, keep, ovr, do_write;
  logic             full, close_eof, close_full, close_nod, reload, close;
  logic [CNT_W-1:0] cnt_next;
  logic [SIZE_W-1:0] size;

  always_comb begin
    start    = in_valid_i && in_sof_i && (state_q == ST_IDLE);
    go       = start && desc_avail_i;
    take     = go || (in_valid_i && (state_q == ST_ACT));
    fail_now = (!start && fail_q) || filt_fail_i;
    keep     = take && !(fail_now && !pass_filt_i);
    ovr      = keep && !wr_ready_i;
    do_write = keep && wr_ready_i;
    close_eof  = take && in_eof_i && !ovr;
    close_full = full && !in_eof_i;
    reload     = close_full && desc_avail_i;
    close_nod  = close_full && !desc_avail_i;
    close      = ovr || close_eof || close_full;
    size       = SIZE_W'(cnt_next - CNT_W'(1));
    state_d = state_q;
    if (take) state_d = (ovr || close_eof || close_nod) ? ST_IDLE : ST_ACT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) fail_q <= fail_now;
    end
  end

  rxfs_frag_ctr #(.SIZE_W(SIZE_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go), .reload_i(reload),
    .write_i(do_write), .buf_size_i(buf_size_i),
    .cnt_next_o(cnt_next), .full_o(full)
  );

  rxfs_wr_stage #(.DATA_W(DATA_W)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .write_i(do_write), .data_i(in_data_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  rxfs_stat_pack #(.SIZE_W(SIZE_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .close_i(close), .size_i(size),
    .last_i(!reload), .ovr_i(ovr), .nodesc_i(close_nod), .fail_i(fail_now),
    .mac_en_i(close_eof), .mac_i(mac_stat_i),
    .stat_valid_o(stat_valid_o), .stat_word_o(stat_word_o)
  );

  // writes seen since the previous status word
  logic [CNT_W-1:0] wr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wr_seen_q <= '0;
    else if (stat_valid_o) wr_seen_q <= '0;
    else                   wr_seen_q <= wr_seen_q + CNT_W'(wr_en_o);
  end

  a_r2_size_matches_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> stat_word_o[SIZE_W-1:0] ==
                     SIZE_W'(wr_seen_q + CNT_W'(wr_en_o) - CNT_W'(1)));
  a_r1_write_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(in_valid_i));
  a_r5_nonlast_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && !stat_word_o[B_LAST]) |->
      (stat_word_o[B_ALN:B_CTRL] == '0 && !stat_word_o[B_ERR]));
  a_r9_nodesc_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_word_o[B_NODESC]) |->
      (stat_word_o[B_LAST] && !stat_word_o[B_OVR]));
  a_r10_overrun_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_word_o[B_OVR]) |->
      (stat_word_o[B_LAST] && stat_word_o[B_ERR]));
endmodule

// File: tb/rx_frag_status_bench.sv
module rx_frag_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, filt = 0, pass_filt = 0;
  logic desc_avail = 0, wr_ready = 1;
  logic [7:0] in_data = 0;
  logic [8:0] mac_stat = 0;
  logic [10:0] buf_size = 0;
  logic wr_en, stat_valid;
  logic [7:0] wr_data;
  logic [31:0] stat_word;

  always #10 clk = ~clk;

  rx_frag_status u_rx_frag_status (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .mac_stat_i(mac_stat),
    .filt_fail_i(filt), .pass_filt_i(pass_filt), .desc_avail_i(desc_avail),
    .buf_size_i(buf_size), .wr_ready_i(wr_ready), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .stat_valid_o(stat_valid), .stat_word_o(stat_word)
  );

  int checks = 0, errors = 0;
  int n_s = 0, n_b = 0, rd_s = 0, rd_b = 0;
  logic [31:0] exp_stat [4096];
  logic [7:0]  exp_byte [4096];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_stat(input int cnt, input bit last, input bit ovr,
      input bit nod, input bit fail, input logic [8:0] mac, input bit eofst);
    logic [31:0] s;
    s = '0;
    s[10:0] = 11'(cnt - 1);
    if (eofst) begin
      s[18] = mac[0]; s[19] = mac[1]; s[20] = fail; s[21] = mac[2];
      s[22] = mac[3]; s[23] = mac[4]; s[24] = mac[5]; s[25] = mac[6];
      s[26] = mac[7]; s[27] = mac[8];
    end
    s[28] = ovr; s[29] = nod; s[30] = last;
    s[31] = s[23] | s[24] | s[25] | s[26] | s[27] | s[28];
    return s;
  endfunction

  task automatic cmp_stat(input logic [31:0] a, input logic [31:0] e);
    chk(a[10:0] == e[10:0], "R2", "size", a, e);
    chk(a[17:11] == 7'd0, "R2", "pad", a, e);
    chk(a[30] == e[30], "R3 R4", "last", a, e);
    if (!e[30]) chk(a[27:18] == 10'd0, "R5", "nonlast flags", a, e);
    else        chk(a[27:18] == e[27:18], "R6", "mac flags", a, e);
    chk(a[20] == e[20], "R8", "failfilter", a, e);
    chk(a[31] == e[31], "R7", "error", a, e);
    chk(a[29] == e[29], "R9", "nodesc", a, e);
    chk(a[28] == e[28], "R10", "overrun", a, e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (rd_b < n_b) chk(wr_data == exp_byte[rd_b], "R1", "byte", 32'(wr_data), 32'(exp_byte[rd_b]));
        else chk(1'b0, "R1", "unexpected write", 32'(wr_data), 32'h0);
        rd_b++;
      end
      if (stat_valid) begin
        if (rd_s < n_s) cmp_stat(stat_word, exp_stat[rd_s]);
        else chk(1'b0, "R3", "unexpected status", stat_word, 32'h0);
        rd_s++;
      end
    end
  end

  task automatic settle(input string rq);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; filt = 0; wr_ready = 1;
    repeat (3) @(negedge clk);
    chk(rd_b == n_b, rq, "write count", 32'(rd_b), 32'(n_b));
    chk(rd_s == n_s, rq, "status count", 32'(rd_s), 32'(n_s));
  endtask

  task automatic run_frame(input int len, input int cap, input int ndesc, input int fail_pos,
      input bit pass, input int ovr_pos, input logic [8:0] mac, input int tag);
    int used = 0;
    int cnt = 0;
    bit fail = 0;
    bit active = 1;
    bit drop;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(tag * 7 + i * 13 + 1);
      in_sof = (i == 0); in_eof = (i == len - 1);
      mac_stat = (i == len - 1) ? mac : ~mac;
      filt = (i == fail_pos); pass_filt = pass;
      desc_avail = (i == 0) ? (ndesc > 0) : (used < ndesc);
      buf_size = 11'(cap); wr_ready = (i != ovr_pos);
      if (active) begin
        if (i == 0) begin
          if (ndesc == 0) active = 0;
          else used++;
        end
        if (active) begin
          if (i == fail_pos) fail = 1;
          drop = fail && !pass;
          if (!drop && i == ovr_pos) begin
            exp_stat[n_s++] = mk_stat(cnt, 1, 1, 0, 0, mac, 0);
            active = 0;
          end else begin
            if (!drop) begin exp_byte[n_b++] = in_data; cnt++; end
            if (i == len - 1) begin
              exp_stat[n_s++] = mk_stat(cnt, 1, 0, 0, fail, mac, 1);
              active = 0;
            end else if (!drop && cnt == cap + 1) begin
              if (used < ndesc) begin
                exp_stat[n_s++] = mk_stat(cnt, 0, 0, 0, 0, mac, 0);
                used++; cnt = 0;
              end else begin
                exp_stat[n_s++] = mk_stat(cnt, 1, 0, 1, 0, mac, 0);
                active = 0;
              end
            end
          end
        end
      end
    end
    settle((ndesc == 0) ? "R11" : "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !stat_valid, "R12", "reset outputs", {30'd0, wr_en, stat_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!wr_en && !stat_valid, "R12", "idle after reset", {30'd0, wr_en, stat_valid}, 32'h0);

    // bytes outside any frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(i); in_eof = (i == 2); desc_avail = 1;
    end
    settle("R1");

    run_frame(4, 2, 0, -1, 0, -1, 9'h1FF, 1);   // R11 no descriptor at start
    run_frame(3, 0, 8, -1, 0, -1, 9'h015, 2);   // R4 one-byte buffers
    run_frame(5, 3, 8, 0, 0, -1, 9'h0A0, 3);    // R8 fail on first byte

    for (int cap = 1; cap <= 3; cap++)
      for (int len = 1; len <= 9; len++)
        for (int s = 0; s < 6; s++) begin
          logic [8:0] mac;
          mac = 9'((len * 53 + cap * 7 + s * 91) & 9'h1FF);
          case (s)
            0: run_frame(len, cap, 8, -1, 0, -1, mac, len + s);
            1: run_frame(len, cap, 1, -1, 0, -1, mac, len + s);       // R9
            2: run_frame(len, cap, 8, len / 2, 0, -1, mac, len + s);  // R8 drop
            3: run_frame(len, cap, 8, len / 2, 1, -1, mac, len + s);  // R8 pass
            4: run_frame(len, cap, 8, -1, 0, len - 1, mac, len + s);  // R10
            default: run_frame(len, cap, 2, -1, 0, len / 2, mac, len + s);
          endcase
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule